// File: doc/BRIEF.md
# Serial Scan-Pattern Expander

This block sits between a tester channel and a scan chain and rebuilds uncompressed scan data from a compact serial stream. The stream is a sequence of codewords. Every codeword opens with a two-bit control code, and that code fixes two numbers: how long a short bit-pattern is and how many times the pattern is repeated. The pattern bits follow the control code directly. After the last pattern bit arrives, the expander replays the pattern back to back on a single-bit scan output, one bit per clock cycle, with a valid strobe.

The compressed input uses a valid/ready handshake, and the block holds ready low while it replays. The output carries only a data bit and a valid flag. It has no backpressure, because a scan chain shifts on every cycle in which valid is high. A long run of identical slices in the scan data therefore costs six input bits for up to sixteen output bits. A short leftover tail can still be sent literally with the single-shot code.

Top module: `vlx_decomp`

## Requirements
- R1: After a synchronous reset, `scan_valid` is 0 and `cw_ready` is 1, and the block waits for the first control-code bit.
- R2: Control code 3 (binary 11) takes a 4-bit pattern and emits it 4 times, which gives 16 output bits.
- R3: Control code 2 (binary 10) takes a 3-bit pattern and emits it 3 times, which gives 9 output bits.
- R4: Control code 1 (binary 01) takes a 2-bit pattern and emits it 2 times, which gives 4 output bits.
- R5: Control code 0 (binary 00) takes a 2-bit pattern and emits it once, which gives 2 output bits.
- R6: The control code arrives most significant bit first. The pattern arrives most significant bit first, and each repetition replays it most significant bit first.
- R7: `cw_ready` stays low from the edge that accepts the last pattern bit until the edge that registers the last replayed bit. Input bits offered while `cw_ready` is low have no effect on the output.
- R8: One codeword's output bits appear on consecutive cycles with `scan_valid` high. The first bit appears one cycle after the last pattern bit is accepted. `scan_valid` is low whenever no replay is in progress.
- R9: Idle cycles with `cw_valid` low, placed anywhere in the input stream, do not change the expanded output.
- R10: A reset in the middle of a codeword or a replay discards the partial codeword, clears `scan_valid` and returns the block to waiting for a control code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_valid | input | 1 | Compressed input bit is valid |
| cw_bit | input | 1 | Compressed input bit |
| cw_ready | output | 1 | Block can accept a compressed bit |
| scan_valid | output | 1 | Scan output bit is valid |
| scan_bit | output | 1 | Expanded scan data bit |

## Verification
An input bit is taken on a rising edge on which both `cw_valid` and `cw_ready` are high. The first expanded bit becomes visible one cycle after the edge that takes the last pattern bit, and the rest of that codeword's bits follow with no gap. The bench drives inputs on the falling edge. It reads `cw_ready` there, because that value stays stable through the next rising edge. A monitor pops one expected bit from the scoreboard on each falling edge where `scan_valid` is high, so bit order and adjacency are checked without counting absolute cycles. A codeword is queued before its first bit is driven, so no result can arrive before its expectation.

// File: rtl/vlx_pkg.sv
package vlx_pkg;
  localparam int unsigned CODE_W = 2;
  typedef logic [CODE_W-1:0] code_t;

  // Pattern length selected by a control code.
  function automatic int unsigned pat_len(code_t c);
    return (c == '0) ? 2 : int'(c) + 1;
  endfunction

  // Number of times the pattern is replayed.
  function automatic int unsigned rep_num(code_t c);
    return (c == '0) ? 1 : int'(c) + 1;
  endfunction
endpackage

// File: rtl/vlx_rx.sv
module vlx_rx
  import vlx_pkg::*;
#(
  parameter int unsigned PAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             load,
  output logic [PAT_W-1:0] load_pat,
  output code_t            load_code
);
  localparam int unsigned CNT_W = $clog2(PAT_W + 1);

  typedef enum logic {PH_CTRL, PH_PAT} phase_t;

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  code_t            code_q;
  logic [PAT_W-1:0] shreg;
  logic [CNT_W-1:0] need;
  logic             take;

  assign take      = in_valid & enable;
  assign need      = CNT_W'(pat_len(code_q));
  assign load_pat  = {shreg[PAT_W-2:0], in_bit};
  assign load_code = code_q;

  always_comb begin
    load = take && (phase == PH_PAT) && (cnt == need - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_CTRL;
      cnt    <= '0;
      code_q <= '0;
      shreg  <= '0;
    end else if (take) begin
      case (phase)
        PH_CTRL: begin
          code_q <= {code_q[CODE_W-2:0], in_bit};
          if (cnt == CNT_W'(CODE_W - 1)) begin
            phase <= PH_PAT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          shreg <= load_pat;
          if (load) begin
            phase <= PH_CTRL;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/vlx_replay.sv
module vlx_replay
  import vlx_pkg::*;
#(
  parameter int unsigned PAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PAT_W-1:0] load_pat,
  input  code_t            load_code,
  output logic             busy,
  output logic             out_valid,
  output logic             out_bit
);
  localparam int unsigned IDX_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;

  logic [PAT_W-1:0] pat_q;
  logic [IDX_W-1:0] top_idx;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] reps_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      pat_q     <= '0;
      top_idx   <= '0;
      idx       <= '0;
      reps_left <= '0;
    end else if (load) begin
      busy      <= 1'b1;
      out_valid <= 1'b0;
      pat_q     <= load_pat;
      top_idx   <= IDX_W'(pat_len(load_code) - 1);
      idx       <= IDX_W'(pat_len(load_code) - 1);
      reps_left <= IDX_W'(rep_num(load_code) - 1);
    end else if (busy) begin
      out_valid <= 1'b1;
      out_bit   <= pat_q[idx];
      if (idx == '0) begin
        idx <= top_idx;
        if (reps_left == '0) begin
          busy <= 1'b0;
        end else begin
          reps_left <= reps_left - 1'b1;
        end
      end else begin
        idx <= idx - 1'b1;
      end
    end else begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vlx_decomp.sv
module vlx_decomp
  import vlx_pkg::*;
#(
  parameter int unsigned PAT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cw_valid,
  input  logic cw_bit,
  output logic cw_ready,
  output logic scan_valid,
  output logic scan_bit
);
  logic             busy;
  logic             load;
  logic [PAT_W-1:0] load_pat;
  code_t            load_code;

  assign cw_ready = ~busy;

  vlx_rx #(.PAT_W(PAT_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .enable    (cw_ready),
    .in_valid  (cw_valid),
    .in_bit    (cw_bit),
    .load      (load),
    .load_pat  (load_pat),
    .load_code (load_code)
  );

  vlx_replay #(.PAT_W(PAT_W)) u_replay (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_pat  (load_pat),
    .load_code (load_code),
    .busy      (busy),
    .out_valid (scan_valid),
    .out_bit   (scan_bit)
  );
endmodule

// File: rtl/vlx_decomp_chk.sv
module vlx_decomp_chk (
  input logic clk,
  input logic rst,
  input logic cw_valid,
  input logic cw_bit,
  input logic cw_ready,
  input logic scan_valid,
  input logic scan_bit
);
  logic [4:0] run;

  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else if (scan_valid) run <= run + 1'b1;
    else run <= '0;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!scan_valid && cw_ready));

  // R7
  stall_emits_chk: assert property (@(posedge clk) disable iff (rst)
    !cw_ready |=> scan_valid);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cw_ready |=> !scan_valid);

  // R8
  run_length_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(scan_valid) && !$past(rst)) |->
      (run == 5'd2 || run == 5'd4 || run == 5'd9 || run == 5'd16));
endmodule

bind vlx_decomp vlx_decomp_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cw_valid   (cw_valid),
  .cw_bit     (cw_bit),
  .cw_ready   (cw_ready),
  .scan_valid (scan_valid),
  .scan_bit   (scan_bit)
);

// File: tb/vlx_decomp_test.sv
module vlx_decomp_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cw_valid = 1'b0;
  logic cw_bit = 1'b0;
  logic cw_ready, scan_valid, scan_bit;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  vlx_decomp uut (
    .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw_bit(cw_bit),
    .cw_ready(cw_ready), .scan_valid(scan_valid), .scan_bit(scan_bit)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: cycles=%0d expected < 150000", cycles);
      finish_run();
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && scan_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R8: unexpected scan bit %0b, expected no output", scan_bit);
      end else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (scan_bit !== e) begin
          fails++;
          $display("FAIL %s: scan_bit=%0b expected %0b", t, scan_bit, e);
        end
      end
    end
  end

  // Offers one bit; entered and left at a falling edge.
  task automatic put_bit(input logic b, input bit stall);
    forever begin
      cw_valid = 1'b1;
      if (cw_ready) begin
        cw_bit = b;
        @(negedge clk);
        break;
      end
      cw_bit = 1'($urandom);  // R7: garbage offered while not ready
      @(negedge clk);
    end
    cw_valid = 1'b0;
    cw_bit   = 1'($urandom);
    if (stall && ($urandom % 3 == 0)) repeat ($urandom % 4) @(negedge clk);
  endtask

  task automatic send_cw(input logic [1:0] code, input logic [3:0] pat,
                         input string tag, input bit stall);
    int len, rep;
    case (code)
      2'b11: begin len = 4; rep = 4; end
      2'b10: begin len = 3; rep = 3; end
      2'b01: begin len = 2; rep = 2; end
      default: begin len = 2; rep = 1; end
    endcase
    for (int r = 0; r < rep; r++)
      for (int i = len - 1; i >= 0; i--) begin
        exp_q.push_back(pat[i]);
        tag_q.push_back(tag);
      end
    put_bit(code[1], stall);
    put_bit(code[0], stall);
    for (int i = len - 1; i >= 0; i--) put_bit(pat[i], stall);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_idle(input string tag);
    checks++;
    if (scan_valid !== 1'b0 || cw_ready !== 1'b1) begin
      fails++;
      $display("FAIL %s: scan_valid=%0b cw_ready=%0b expected 0 1", tag, scan_valid, cw_ready);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst = 1'b0;
    @(negedge clk);

    // R6: order of code, pattern and replay
    send_cw(2'b11, 4'b1000, "R6", 1'b0);
    send_cw(2'b10, 4'b0100, "R6", 1'b0);
    drain();

    // R2..R5 directed
    send_cw(2'b11, 4'b1101, "R2", 1'b0);
    send_cw(2'b10, 4'b0011, "R3", 1'b0);
    send_cw(2'b01, 4'b0001, "R4", 1'b0);
    send_cw(2'b00, 4'b0010, "R5", 1'b0);
    drain();

    // R7: next codeword offered during replay with garbage while not ready
    send_cw(2'b11, 4'b1010, "R7", 1'b0);
    checks++;
    if (cw_ready !== 1'b0) begin
      fails++;
      $display("FAIL R7: cw_ready=%0b expected 0 during replay", cw_ready);
    end
    send_cw(2'b10, 4'b0110, "R7", 1'b0);
    drain();

    // R9: idle gaps in the input stream
    for (int k = 0; k < 20; k++) send_cw(2'($urandom), 4'($urandom), "R9", 1'b1);
    drain();

    // R10: reset inside a codeword
    put_bit(1'b1, 1'b0); put_bit(1'b1, 1'b0); put_bit(1'b0, 1'b0);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check_idle("R10");
    send_cw(2'b01, 4'b0010, "R10", 1'b0);
    drain();

    // R10: reset during a replay
    send_cw(2'b11, 4'b0111, "R10", 1'b0);
    repeat (4) @(negedge clk);
    rst = 1'b1; exp_q.delete(); tag_q.delete();
    @(negedge clk); @(negedge clk); rst = 1'b0;
    check_idle("R10");
    send_cw(2'b00, 4'b0001, "R10", 1'b0);
    drain();

    // Random streams against the reference expansion
    for (int k = 0; k < 300; k++) begin
      logic [1:0] c;
      c = 2'($urandom);
      send_cw(c, 4'($urandom),
              (c == 2'b11) ? "R2" : (c == 2'b10) ? "R3" : (c == 2'b01) ? "R4" : "R5",
              1'b1);
    end
    drain();

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R8: %0d bits missing, expected 0", exp_q.size());
    end
    check_idle("R8");
    finish_run();
  end
endmodule